// File: doc/BRIEF.md
# Sequential Trigger Stage Capture Controller

This block holds a capture buffer back until a chain of trigger conditions has been met, one after another. Comparator logic elsewhere supplies one match flag per stage. After an arm pulse the controller watches stage 0 only. When stage 0 matches it moves on to stage 1, and so on. The match of the last configured stage starts the capture: the probe word present in that same cycle is stored as entry 0, and the following cycles fill the rest of the buffer. If the stage count is zero, the buffer starts filling in the first cycle after arming.

Each stage has its own cycle budget. If the stage does not match within that budget, the sequence is abandoned, a timeout flag is raised, and the buffer keeps its previous contents. When the buffer is full a done flag is set. A host then reads the stored words through a synchronous address/data port.

Top module: `trig_seq_capture`

## Requirements
- R1: Stages are evaluated strictly in order. While waiting on stage k, a match on any other stage has no effect. `stageIdx` moves from k to k+1 only on a stage-k match. Several flags high at once advance it by exactly one.
- R2: When the final stage (index numStages-1) matches, the `sampleIn` word of that cycle is stored at address 0. Entry j holds the word of the j-th cycle after it.
- R3: With `numStages` = 0, arming starts capture at once. Entry 0 is the `sampleIn` word of the first cycle after the arm pulse.
- R4: Stage k's budget is field k of `stageTimeout` (bits k*TO_W upward). With a budget of L>0, if no match occurs in the L cycles counted from entry to the stage, then in the next cycle `timedOut`=1, `busy`=0 and `done`=0, and the buffer is unchanged. L=0 disables the timeout.
- R5: The cycle budget restarts from zero each time the controller advances to a new stage.
- R6: A match in the last cycle of a stage's budget is honoured, and no timeout is raised.
- R7: Capture writes DEPTH consecutive cycles. `done` rises in the cycle after the last write, `busy` falls at the same time, and `done` stays high until the next arm.
- R8: `rdData` presents the entry at `rdAddr` one clock after the address is applied.
- R9: An arm pulse clears the stage index, the write position, `done` and `timedOut`, and restarts the sequence. This holds in every state, including during a capture.
- R10: A `numStages` value above NUM_STAGES is treated as NUM_STAGES. The count is latched at arm.
- R11: After reset, `busy`, `done`, `timedOut` and `stageIdx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle arm/restart pulse |
| numStages | input | $clog2(NUM_STAGES+1) | Count of active stages, latched at arm |
| stageMatch | input | NUM_STAGES | Per-stage match flags from comparators |
| stageTimeout | input | NUM_STAGES*TO_W | Per-stage cycle budgets, stage 0 in the low field |
| sampleIn | input | SAMPLE_W | Probe word to store |
| rdAddr | input | $clog2(DEPTH) | Buffer read address |
| busy | output | 1 | Sequence or capture in progress |
| done | output | 1 | Buffer full, sticky until arm |
| timedOut | output | 1 | A stage ran out of budget, sticky until arm |
| stageIdx | output | IDX_W | Stage currently awaited |
| rdData | output | SAMPLE_W | Registered read data |

## Verification
The sharpest collision is a stage match that lands in the very cycle the stage's budget runs out. The bench provokes it by raising the match flag exactly at cycle L-1 of the budget. It then judges that capture went ahead and that `timedOut` stayed low. The second collision is an arm pulse arriving mid-capture, while writes are still going on. The bench judges it by two results: entry 0 must be the first word after the new arm, and `done` must appear exactly DEPTH cycles later.

// File: rtl/trig_cap_pkg.sv
package trig_cap_pkg;
  typedef struct packed {
    logic wrEn;
    logic ptrClr;
    logic tmrClr;
  } capStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CAPT = 2'd2
  } capState_t;
endpackage

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
  import trig_cap_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int TO_W       = 16,
  localparam int CNT_W     = $clog2(NUM_STAGES + 1),
  localparam int IDX_W     = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       arm,
  input  logic [CNT_W-1:0]           numStages,
  input  logic [NUM_STAGES-1:0]      stageMatch,
  input  logic [NUM_STAGES*TO_W-1:0] stageTimeout,
  input  logic                       tmrExpire,
  input  logic                       lastWrite,
  output capStrobe_t                 strb,
  output logic [TO_W-1:0]            stgLimit,
  output logic                       busy,
  output logic                       done,
  output logic                       timedOut,
  output logic [IDX_W-1:0]           stageIdx
);
  capState_t        state;
  logic [CNT_W-1:0] effCnt;
  logic [CNT_W-1:0] armCnt;
  logic [TO_W-1:0]  limArr [NUM_STAGES];
  logic             curMatch;
  logic             isFinal;
  logic             fire;
  logic             advance;
  logic             abort;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_lim
    assign limArr[k] = stageTimeout[k*TO_W +: TO_W];
  end

  assign armCnt   = (numStages > CNT_W'(NUM_STAGES)) ? CNT_W'(NUM_STAGES) : numStages;
  assign stgLimit = limArr[stageIdx];
  assign curMatch = stageMatch[stageIdx];
  assign isFinal  = (CNT_W'(stageIdx) + CNT_W'(1)) == effCnt;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb    = '0;
    fire    = 1'b0;
    advance = 1'b0;
    abort   = 1'b0;
    if (arm) begin
      strb.ptrClr = 1'b1;
      strb.tmrClr = 1'b1;
    end else begin
      case (state)
        ST_WAIT: begin
          if (curMatch) begin
            if (isFinal) begin
              fire      = 1'b1;
              strb.wrEn = 1'b1;
            end else begin
              advance     = 1'b1;
              strb.tmrClr = 1'b1;
            end
          end else if (tmrExpire) begin
            abort = 1'b1;
          end
        end
        ST_CAPT: strb.wrEn = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      effCnt   <= '0;
      stageIdx <= '0;
      done     <= 1'b0;
      timedOut <= 1'b0;
    end else if (arm) begin
      state    <= (armCnt == '0) ? ST_CAPT : ST_WAIT;
      effCnt   <= armCnt;
      stageIdx <= '0;
      done     <= 1'b0;
      timedOut <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (fire) begin
            state <= lastWrite ? ST_IDLE : ST_CAPT;
            done  <= lastWrite;
          end else if (advance) begin
            stageIdx <= stageIdx + 1'b1;
          end else if (abort) begin
            state    <= ST_IDLE;
            timedOut <= 1'b1;
          end
        end
        ST_CAPT: begin
          if (lastWrite) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !arm) |=> (stageIdx == $past(stageIdx) || stageIdx == $past(stageIdx) + 1'b1)); // R1
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timedOut) |-> (!busy && !done)); // R4
  AST_MATCH_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !arm && curMatch) |=> !timedOut); // R6
  AST_DONE_ON_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(lastWrite)); // R7
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> (!done && !timedOut && stageIdx == '0)); // R9
endmodule

// File: rtl/trig_cap_dpath.sv
module trig_cap_dpath
  import trig_cap_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int DEPTH    = 4096,
  parameter int TO_W     = 16,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  capStrobe_t          strb,
  input  logic [TO_W-1:0]     stgLimit,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic                tmrExpire,
  output logic                lastWrite,
  output logic [SAMPLE_W-1:0] rdData
);
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0]   wrPtr;
  logic [TO_W-1:0]     timer;

  assign lastWrite = (wrPtr == ADDR_W'(DEPTH - 1));
  assign tmrExpire = (stgLimit != '0) && (timer == stgLimit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      timer <= '0;
    end else begin
      if (strb.ptrClr)    wrPtr <= '0;
      else if (strb.wrEn) wrPtr <= wrPtr + 1'b1;
      if (strb.tmrClr)    timer <= '0;
      else                timer <= timer + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrPtr] <= sampleIn;
    rdData <= mem[rdAddr];
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrEn && !strb.ptrClr) |=> $stable(wrPtr)); // R2
endmodule

// File: rtl/trig_seq_capture.sv
module trig_seq_capture
  import trig_cap_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int SAMPLE_W   = 12,
  parameter int DEPTH      = 4096,
  parameter int TO_W       = 16,
  localparam int CNT_W     = $clog2(NUM_STAGES + 1),
  localparam int IDX_W     = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       arm,
  input  logic [CNT_W-1:0]           numStages,
  input  logic [NUM_STAGES-1:0]      stageMatch,
  input  logic [NUM_STAGES*TO_W-1:0] stageTimeout,
  input  logic [SAMPLE_W-1:0]        sampleIn,
  input  logic [ADDR_W-1:0]          rdAddr,
  output logic                       busy,
  output logic                       done,
  output logic                       timedOut,
  output logic [IDX_W-1:0]           stageIdx,
  output logic [SAMPLE_W-1:0]        rdData
);
  capStrobe_t      strb;
  logic [TO_W-1:0] stgLimit;
  logic            tmrExpire;
  logic            lastWrite;

  trig_seq_ctrl #(.NUM_STAGES(NUM_STAGES), .TO_W(TO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .arm(arm), .numStages(numStages),
    .stageMatch(stageMatch), .stageTimeout(stageTimeout),
    .tmrExpire(tmrExpire), .lastWrite(lastWrite), .strb(strb),
    .stgLimit(stgLimit), .busy(busy), .done(done),
    .timedOut(timedOut), .stageIdx(stageIdx)
  );

  trig_cap_dpath #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .TO_W(TO_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .stgLimit(stgLimit),
    .sampleIn(sampleIn), .rdAddr(rdAddr), .tmrExpire(tmrExpire),
    .lastWrite(lastWrite), .rdData(rdData)
  );
endmodule

// File: tb/trig_seq_capture_tb.sv
module trig_seq_capture_tb;
  localparam int NS = 4;
  localparam int SW = 12;
  localparam int DP = 4096;
  localparam int TW = 16;
  localparam int CW = $clog2(NS + 1);
  localparam int AW = $clog2(DP);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          arm = 1'b0;
  logic [CW-1:0] numStages = '0;
  logic [NS-1:0] stageMatch = '0;
  logic [NS*TW-1:0] stageTimeout = '0;
  logic [SW-1:0] sampleIn = '0;
  logic [AW-1:0] rdAddr = '0;
  logic          busy, done, timedOut;
  logic [1:0]    stageIdx;
  logic [SW-1:0] rdData;
  int nChk = 0;
  int nFail = 0;
  logic [SW-1:0] lastE0;

  always #5ns clk = ~clk;

  trig_seq_capture u_dut (
    .clk(clk), .rstN(rstN), .arm(arm), .numStages(numStages),
    .stageMatch(stageMatch), .stageTimeout(stageTimeout), .sampleIn(sampleIn),
    .rdAddr(rdAddr), .busy(busy), .done(done), .timedOut(timedOut),
    .stageIdx(stageIdx), .rdData(rdData)
  );

  initial forever begin
    @(negedge clk);
    sampleIn = sampleIn + 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nx();
    @(negedge clk);
    #1;
  endtask

  task automatic armIt(input logic [CW-1:0] n);
    nx();
    numStages = n;
    arm = 1'b1;
    nx();
    arm = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [SW-1:0] v);
    nx();
    rdAddr = a;
    nx();
    v = rdData;
  endtask

  task automatic waitDone();
    for (int i = 0; i < DP + 10 && !done; i++) nx();
  endtask

  task automatic t_reset();
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 timedOut", timedOut, 0);
    chk("R11 stageIdx", stageIdx, 0);
  endtask

  task automatic t_immediate();
    logic [SW-1:0] s0, v;
    armIt(0);
    s0 = sampleIn;
    repeat (DP - 1) nx();
    chk("R7 done before last write", done, 0);
    chk("R7 busy during capture", busy, 1);
    nx();
    chk("R7 done after full", done, 1);
    chk("R7 busy after full", busy, 0);
    rd(0, v);
    chk("R3 entry0 immediate", v, s0);
    rd(AW'(DP - 1), v);
    chk("R8 last entry", v, SW'(s0 + SW'(DP - 1)));
    chk("R7 done sticky", done, 1);
  endtask

  task automatic t_inorder();
    logic [SW-1:0] t, v;
    stageTimeout = '0;
    armIt(2);
    chk("R9 arm clears done", done, 0);
    repeat (20) nx();
    chk("R4 zero budget never expires", timedOut, 0);
    stageMatch = 4'b0010;
    nx();
    chk("R1 later stage ignored", stageIdx, 0);
    stageMatch = 4'b0001;
    nx();
    chk("R1 advance on stage0", stageIdx, 1);
    stageMatch = 4'b0001;
    nx();
    chk("R1 earlier stage ignored", stageIdx, 1);
    chk("R1 still busy", busy, 1);
    stageMatch = 4'b0010;
    t = sampleIn;
    nx();
    stageMatch = '0;
    waitDone();
    chk("R2 done reached", done, 1);
    rd(0, v);
    chk("R2 entry0 is trigger cycle", v, t);
    lastE0 = v;
    rd(1, v);
    chk("R2 entry1 follows", v, SW'(t + 1'b1));
  endtask

  task automatic t_multi();
    stageTimeout = '0;
    armIt(3);
    stageMatch = 4'b0111;
    nx();
    stageMatch = '0;
    chk("R1 several flags advance one", stageIdx, 1);
    chk("R1 no capture yet", busy, 1);
  endtask

  task automatic t_timeout();
    logic [SW-1:0] v;
    stageTimeout = {16'd0, 16'd0, 16'd0, 16'd5};
    armIt(2);
    repeat (4) nx();
    chk("R4 no timeout in budget", timedOut, 0);
    chk("R4 busy in budget", busy, 1);
    nx();
    chk("R4 timedOut set", timedOut, 1);
    chk("R4 busy cleared", busy, 0);
    chk("R4 done not set", done, 0);
    rd(0, v);
    chk("R4 buffer untouched", v, lastE0);
  endtask

  task automatic t_restart();
    stageTimeout = {16'd0, 16'd0, 16'd3, 16'd10};
    armIt(2);
    chk("R9 arm clears timedOut", timedOut, 0);
    repeat (7) nx();
    stageMatch = 4'b0001;
    nx();
    stageMatch = '0;
    nx();
    nx();
    chk("R5 stage1 in budget", timedOut, 0);
    chk("R5 at stage1", stageIdx, 1);
    nx();
    chk("R5 stage1 budget from zero", timedOut, 1);
  endtask

  task automatic t_edge_and_rearm();
    logic [SW-1:0] s0, v;
    stageTimeout = {16'd0, 16'd0, 16'd0, 16'd4};
    armIt(1);
    repeat (3) nx();
    stageMatch = 4'b0001;
    nx();
    stageMatch = '0;
    chk("R6 match on last budget cycle", timedOut, 0);
    chk("R6 capture running", busy, 1);
    repeat (50) nx();
    armIt(0);
    s0 = sampleIn;
    chk("R9 rearm mid capture", done, 0);
    repeat (DP - 1) nx();
    chk("R9 not done early", done, 0);
    nx();
    chk("R9 done DEPTH after rearm", done, 1);
    rd(0, v);
    chk("R9 entry0 after rearm", v, s0);
  endtask

  task automatic t_clamp();
    logic [SW-1:0] t, v;
    stageTimeout = '0;
    armIt(3'd7);
    for (int k = 0; k < NS; k++) begin
      stageMatch = NS'(1) << k;
      if (k == NS - 1) begin
        chk("R10 at last stage", stageIdx, 3);
        t = sampleIn;
      end
      nx();
    end
    stageMatch = '0;
    waitDone();
    chk("R10 clamped count completes", done, 1);
    rd(0, v);
    chk("R10 entry0", v, t);
  endtask

  initial begin
    repeat (3) nx();
    rstN = 1'b1;
    nx();
    t_reset();
    t_immediate();
    t_inorder();
    t_multi();
    t_timeout();
    t_restart();
    t_edge_and_rearm();
    t_clamp();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule